// File: doc/BRIEF.md
# Move, Extend and Exchange Engine

This block carries out single data-transfer operations between a register-side interface and a byte-wide memory port. A caller presents an operation code, the location kind and size of each operand, a register or immediate value and a memory address, then pulses `start`. The engine decides whether the combination is legal. If it is, the engine runs the byte accesses the operation needs, one per acknowledged cycle. It then returns the register-side result with a one-cycle `done`. A full-pointer load also returns a segment value.

The supported operations are a plain move, a move with zero fill, a move with sign fill, an exchange between a register and memory, and a full-pointer load. Multi-byte memory values are assembled and written little-endian. The caller computes the address and owns the register file. The engine only reads `reg_in` and `addr_in` on the cycle `start` is accepted.

Top module: `mvx_engine`

## Requirements
- R1: Memory values are little-endian. The byte at address A+k fills bits 8k+7..8k of the value. Reading a 16-bit value where A holds 00h and A+1 holds FFh returns 0000FF00h. Operation codes are 0 move, 1 zero-extend, 2 sign-extend, 3 exchange and 4 pointer load. Location codes are 0 register, 1 memory and 2 immediate. Size codes are 0 for 8 bits, 1 for 16, 2 for 32 and 3 for 64.
- R2: Zero-extend returns the source value with every bit above the source width, up to the destination width, cleared. For example, 8100h taken from 16 to 32 bits gives 00008100h.
- R3: Sign-extend copies the most significant source bit into every bit above the source width, up to the destination width. Bits above the destination width are zero. For example, 8100h taken from 16 to 32 bits gives FFFF8100h, and 80h taken from 8 to 16 bits gives 0000FF80h.
- R4: An operation whose source is a register or an immediate and whose destination is a register makes no memory access. It completes in the cycle after `start`, and the result is the value truncated to the destination size.
- R5: A move into memory writes byte k of the register value to address+k, in rising address order.
- R6: An exchange, with a memory destination and a register source, first reads every byte of the memory operand and only then writes the register value back, lowest address first. Its result is the old memory value.
- R7: A pointer load reads the destination-sized value at the address. It then reads a 16-bit segment value from address+2 when the destination is 16 bits, or from address+4 when it is 32 bits.
- R8: Illegal combinations assert `err` for one cycle, in the cycle after `start`, with no memory access and no `done`. These are an immediate destination, an extension with a destination that is not a register, an extension with an immediate source, an extension that does not widen, unequal sizes on a move or exchange, an exchange that is not memory-destination with register-source, a pointer load with an 8-bit destination or a source that is not memory, a memory-to-memory move, an unknown operation code, and a size above the configured maximum.
- R9: `mem_req` holds its address and direction stable until `mem_ack`. Each acknowledged cycle transfers exactly one byte, and the operation makes exactly the number of accesses its sizes imply.
- R10: `done` is a single-cycle pulse. For a memory operation, it comes in the cycle right after the final acknowledged access.
- R11: A `start` pulse that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 3 | Operation code |
| dst_loc | input | 2 | Destination location kind |
| src_loc | input | 2 | Source location kind |
| dst_sz | input | 2 | Destination size code |
| src_sz | input | 2 | Source size code |
| reg_in | input | 8*MAXB | Register or immediate operand value |
| addr_in | input | AW | Memory operand address |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Byte access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_ack | input | 1 | Access accepted this cycle |
| mem_rdata | input | 8 | Read byte, valid with mem_ack |
| done | output | 1 | Operation complete pulse |
| err | output | 1 | Illegal combination pulse |
| result | output | 8*MAXB | Register-side result |
| seg_val | output | 8*SEGB | Segment value from a pointer load |

## Verification
The bench builds the engine with MAXB = 4 and AW = 10, so a 1 KB byte array can model the whole address space. With MAXB = 4, size code 3 falls above the configured maximum, which lets the bench reach the oversize rejection. The 32-bit limit also puts the widest pointer load, six accesses, and the eight-access exchange within reach. Runs with an ack that stalls on alternate cycles exercise request holding under back-pressure, and a start pulse injected during one of those runs exercises the ignore rule.

// File: rtl/mvx_pkg.sv
package mvx_pkg;

   typedef enum logic [2:0] {
      MVX_MOVE = 3'd0,
      MVX_ZEXT = 3'd1,
      MVX_SEXT = 3'd2,
      MVX_XCHG = 3'd3,
      MVX_LPTR = 3'd4
   } mvx_op_e;

   localparam logic [1:0] LOC_REG = 2'd0;
   localparam logic [1:0] LOC_MEM = 2'd1;
   localparam logic [1:0] LOC_IMM = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_SEG,
      ST_WRITE,
      ST_FIN
   } mvx_state_e;

   // Decoded plan for one operation
   typedef struct packed {
      logic       illegal;
      logic [3:0] n_rd;
      logic [3:0] n_wr;
      logic       seg;
      logic       sext;
      logic [1:0] ext_sz;
      logic [1:0] dst_sz;
   } mvx_plan_t;

endpackage

// File: rtl/mvx_decode.sv
module mvx_decode
   import mvx_pkg::*;
#(
   parameter int MAXB = 4
) (
   input  logic [2:0] op,
   input  logic [1:0] dst_loc,
   input  logic [1:0] src_loc,
   input  logic [1:0] dst_sz,
   input  logic [1:0] src_sz,
   output mvx_plan_t  plan
);

   localparam int         MAXSZ   = $clog2(MAXB);
   localparam logic [1:0] MAXSZ_C = 2'(MAXSZ);

   logic [3:0] dbytes;
   logic [3:0] sbytes;
   logic       bad;

   assign dbytes = 4'd1 << dst_sz;
   assign sbytes = 4'd1 << src_sz;

   always_comb begin
      plan        = '0;
      bad         = (dst_sz > MAXSZ_C) || (dst_loc == 2'd3) || (src_loc == 2'd3);
      plan.dst_sz = dst_sz;
      plan.ext_sz = dst_sz;
      case (op)
         MVX_MOVE: begin
            bad = bad || (dst_loc == LOC_IMM) || (src_sz != dst_sz)
                      || (dst_loc == LOC_MEM && src_loc == LOC_MEM);
            plan.n_rd = (src_loc == LOC_MEM) ? dbytes : 4'd0;
            plan.n_wr = (dst_loc == LOC_MEM) ? dbytes : 4'd0;
         end
         MVX_ZEXT, MVX_SEXT: begin
            bad = bad || (dst_loc != LOC_REG) || (src_loc == LOC_IMM)
                      || (src_sz >= dst_sz);
            plan.n_rd   = (src_loc == LOC_MEM) ? sbytes : 4'd0;
            plan.ext_sz = src_sz;
            plan.sext   = (op == MVX_SEXT);
         end
         MVX_XCHG: begin
            bad = bad || (dst_loc != LOC_MEM) || (src_loc != LOC_REG)
                      || (src_sz != dst_sz);
            plan.n_rd = dbytes;
            plan.n_wr = dbytes;
         end
         MVX_LPTR: begin
            bad = bad || (dst_loc != LOC_REG) || (src_loc != LOC_MEM)
                      || (dst_sz == 2'd0);
            plan.n_rd = dbytes;
            plan.seg  = 1'b1;
         end
         default: bad = 1'b1;
      endcase
      if (bad) begin
         plan.n_rd = 4'd0;
         plan.n_wr = 4'd0;
         plan.seg  = 1'b0;
      end
      plan.illegal = bad;
   end

endmodule

// File: rtl/mvx_extend.sv
module mvx_extend #(
   parameter int NB = 4
) (
   input  logic [8*NB-1:0] data,
   input  logic [1:0]      ext_sz,
   input  logic [1:0]      dst_sz,
   input  logic            sext,
   output logic [8*NB-1:0] dout
);

   localparam int NSZ = $clog2(NB) + 1;

   logic [4:0] sb;
   logic [4:0] db;
   logic       sign;

   assign sb = 5'd1 << ext_sz;
   assign db = 5'd1 << dst_sz;

   // Top bit of the source field
   always_comb begin
      sign = 1'b0;
      for (int s = 0; s < NSZ; s++) begin
         if (ext_sz == 2'(s)) sign = data[8*(1<<s)-1];
      end
   end

   for (genvar b = 0; b < NB; b++) begin : g_lane
      localparam logic [4:0] LN = 5'(b);
      assign dout[8*b +: 8] = (LN < sb) ? data[8*b +: 8] :
                              (LN < db) ? {8{sign & sext}} : 8'h00;
   end

endmodule

// File: rtl/mvx_seq.sv
module mvx_seq
   import mvx_pkg::*;
#(
   parameter int AW   = 20,
   parameter int MAXB = 4,
   parameter int SEGB = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  mvx_plan_t            plan,
   input  logic [8*MAXB-1:0]    reg_in,
   input  logic [AW-1:0]        addr_in,
   output logic                 busy,
   output logic                 mem_req,
   output logic                 mem_we,
   output logic [AW-1:0]        mem_addr,
   output logic [7:0]           mem_wdata,
   input  logic                 mem_ack,
   input  logic [7:0]           mem_rdata,
   output logic                 done,
   output logic                 err,
   output mvx_plan_t            plan_q,
   output logic [8*MAXB-1:0]    data_o,
   output logic [8*SEGB-1:0]    seg_o
);

   localparam int IXW  = $clog2(MAXB);
   localparam int SIXW = $clog2(SEGB);

   mvx_state_e                  state_q;
   logic [3:0]                  idx_q;
   logic [AW-1:0]               base_q;
   logic [MAXB-1:0][7:0]        dq;
   logic [MAXB-1:0][7:0]        wq;
   logic [SEGB-1:0][7:0]        sq;
   logic                        err_q;
   logic [3:0]                  off;

   assign busy      = (state_q != ST_IDLE);
   assign mem_req   = (state_q == ST_READ) || (state_q == ST_SEG) || (state_q == ST_WRITE);
   assign mem_we    = (state_q == ST_WRITE);
   assign off       = (state_q == ST_SEG) ? (plan_q.n_rd + idx_q) : idx_q;
   assign mem_addr  = base_q + AW'(off);
   assign mem_wdata = wq[idx_q[IXW-1:0]];
   assign done      = (state_q == ST_FIN);
   assign err       = err_q;
   assign data_o    = dq;
   assign seg_o     = sq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         idx_q   <= '0;
         base_q  <= '0;
         dq      <= '0;
         wq      <= '0;
         sq      <= '0;
         err_q   <= 1'b0;
         plan_q  <= '0;
      end else begin
         err_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  if (plan.illegal) begin
                     err_q <= 1'b1;
                  end else begin
                     plan_q <= plan;
                     base_q <= addr_in;
                     dq     <= reg_in;
                     wq     <= reg_in;
                     sq     <= '0;
                     idx_q  <= '0;
                     if (plan.n_rd != 4'd0)      state_q <= ST_READ;
                     else if (plan.n_wr != 4'd0) state_q <= ST_WRITE;
                     else                        state_q <= ST_FIN;
                  end
               end
            end
            ST_READ: begin
               if (mem_ack) begin
                  dq[idx_q[IXW-1:0]] <= mem_rdata;
                  if (idx_q == plan_q.n_rd - 4'd1) begin
                     idx_q <= '0;
                     if (plan_q.seg)                state_q <= ST_SEG;
                     else if (plan_q.n_wr != 4'd0)  state_q <= ST_WRITE;
                     else                           state_q <= ST_FIN;
                  end else begin
                     idx_q <= idx_q + 4'd1;
                  end
               end
            end
            ST_SEG: begin
               if (mem_ack) begin
                  sq[idx_q[SIXW-1:0]] <= mem_rdata;
                  if (idx_q == 4'(SEGB - 1)) begin
                     idx_q   <= '0;
                     state_q <= ST_FIN;
                  end else begin
                     idx_q <= idx_q + 4'd1;
                  end
               end
            end
            ST_WRITE: begin
               if (mem_ack) begin
                  if (idx_q == plan_q.n_wr - 4'd1) begin
                     idx_q   <= '0;
                     state_q <= ST_FIN;
                  end else begin
                     idx_q <= idx_q + 4'd1;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mvx_engine.sv
module mvx_engine
   import mvx_pkg::*;
#(
   parameter int AW   = 20,
   parameter int MAXB = 4,
   parameter int SEGB = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [2:0]          op,
   input  logic [1:0]          dst_loc,
   input  logic [1:0]          src_loc,
   input  logic [1:0]          dst_sz,
   input  logic [1:0]          src_sz,
   input  logic [8*MAXB-1:0]   reg_in,
   input  logic [AW-1:0]       addr_in,
   output logic                busy,
   output logic                mem_req,
   output logic                mem_we,
   output logic [AW-1:0]       mem_addr,
   output logic [7:0]          mem_wdata,
   input  logic                mem_ack,
   input  logic [7:0]          mem_rdata,
   output logic                done,
   output logic                err,
   output logic [8*MAXB-1:0]   result,
   output logic [8*SEGB-1:0]   seg_val
);

   localparam int DW = 8 * MAXB;

   if (!(MAXB == 2 || MAXB == 4 || MAXB == 8)) begin : g_bad_maxb
      $error("mvx_engine: MAXB must be 2, 4 or 8");
   end
   if (!(SEGB == 2 || SEGB == 4)) begin : g_bad_segb
      $error("mvx_engine: SEGB must be 2 or 4");
   end
   if (AW < 4) begin : g_bad_aw
      $error("mvx_engine: AW must be at least 4");
   end

   mvx_plan_t         plan_d;
   mvx_plan_t         plan_q;
   logic [DW-1:0]     data_q;

   mvx_decode #(.MAXB(MAXB)) u_dec (
      .op      (op),
      .dst_loc (dst_loc),
      .src_loc (src_loc),
      .dst_sz  (dst_sz),
      .src_sz  (src_sz),
      .plan    (plan_d)
   );

   mvx_seq #(.AW(AW), .MAXB(MAXB), .SEGB(SEGB)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .plan      (plan_d),
      .reg_in    (reg_in),
      .addr_in   (addr_in),
      .busy      (busy),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .done      (done),
      .err       (err),
      .plan_q    (plan_q),
      .data_o    (data_q),
      .seg_o     (seg_val)
   );

   mvx_extend #(.NB(MAXB)) u_ext (
      .data   (data_q),
      .ext_sz (plan_q.ext_sz),
      .dst_sz (plan_q.dst_sz),
      .sext   (plan_q.sext),
      .dout   (result)
   );

endmodule

// File: rtl/mvx_engine_chk.sv
module mvx_engine_chk #(
   parameter int AW = 20
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ack,
   input logic          done,
   input logic          err
);

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9

   AST_REQ_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy); // R9

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_DONE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_req); // R10

   AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !mem_req && !busy && !done); // R8

   AST_NO_READ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack |=> !mem_req || mem_we); // R6

endmodule

bind mvx_engine mvx_engine_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .mem_req  (mem_req),
   .mem_we   (mem_we),
   .mem_addr (mem_addr),
   .mem_ack  (mem_ack),
   .done     (done),
   .err      (err)
);

// File: tb/sim_mvx_engine.sv
module sim_mvx_engine;

   localparam int CLK_PERIOD = 10;
   localparam int AW_T       = 10;
   localparam int MAXB_T     = 4;
   localparam int DW_T       = 8 * MAXB_T;

   typedef struct {
      bit          is_err;
      logic [31:0] res;
      bit          cs;
      logic [15:0] seg;
      int          n_acc;
      string       tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [2:0]        op = '0;
   logic [1:0]        dst_loc = '0, src_loc = '0, dst_sz = '0, src_sz = '0;
   logic [DW_T-1:0]   reg_in = '0;
   logic [AW_T-1:0]   addr_in = '0;
   logic              busy, mem_req, mem_we, done, err;
   logic [AW_T-1:0]   mem_addr;
   logic [7:0]        mem_wdata;
   logic              mem_ack = 1'b0;
   logic [7:0]        mem_rdata = '0;
   logic [DW_T-1:0]   result;
   logic [15:0]       seg_val;

   logic [7:0] mem [0:(1<<AW_T)-1];
   exp_t       sbq[$];
   exp_t       cur;
   int n_checks = 0, n_fail = 0, n_pushed = 0, n_done = 0;
   int cyc = 0, st_cyc = 0, last_ack_cyc = 0, acc_cnt = 0, exp_cyc = 0;
   bit stall_en = 1'b0, stall_tog = 1'b0, finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mvx_engine #(.AW(AW_T), .MAXB(MAXB_T), .SEGB(2)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .dst_loc(dst_loc), .src_loc(src_loc), .dst_sz(dst_sz), .src_sz(src_sz),
      .reg_in(reg_in), .addr_in(addr_in), .busy(busy),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .done(done), .err(err), .result(result), .seg_val(seg_val)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] expv);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   // Monitor and memory responder, both at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         cyc++;
         if (done || err) begin
            if (sbq.size() == 0) begin
               chk(1'b0, "R11", "completion with no pending start", {62'd0, done, err}, 64'd0);
            end else begin
               cur = sbq.pop_front();
               n_done++;
               chk(err == cur.is_err, cur.tag, "err versus done", 64'(err), 64'(cur.is_err));
               if (!cur.is_err)
                  chk(result == cur.res, cur.tag, "result", 64'(result), 64'(cur.res));
               if (cur.cs)
                  chk(seg_val == cur.seg, cur.tag, "segment value R7", 64'(seg_val), 64'(cur.seg));
               chk(acc_cnt == cur.n_acc, cur.tag, "access count R9", 64'(acc_cnt), 64'(cur.n_acc));
               exp_cyc = (cur.n_acc > 0) ? last_ack_cyc + 1 : st_cyc + 1;
               chk(cyc == exp_cyc, cur.tag, "completion cycle R10", 64'(cyc), 64'(exp_cyc));
            end
         end
         if (start && !busy) begin
            st_cyc  = cyc;
            acc_cnt = 0;
         end
         mem_ack = 1'b0;
         if (mem_req) begin
            stall_tog = stall_en ? !stall_tog : 1'b1;
            if (stall_tog) begin
               mem_ack      = 1'b1;
               acc_cnt++;
               last_ack_cyc = cyc;
               if (mem_we) mem[mem_addr] = mem_wdata;
               else        mem_rdata     = mem[mem_addr];
            end
         end
      end
   end

   task automatic run_op(input logic [2:0] o, input logic [1:0] dl, input logic [1:0] sl,
                         input logic [1:0] ds, input logic [1:0] ss,
                         input logic [31:0] rv, input logic [AW_T-1:0] a,
                         input bit e_err, input logic [31:0] e_res,
                         input bit cs, input logic [15:0] e_seg,
                         input int n_acc, input string tag);
      exp_t it;
      it.is_err = e_err; it.res = e_res; it.cs = cs; it.seg = e_seg;
      it.n_acc = n_acc; it.tag = tag;
      sbq.push_back(it);
      n_pushed++;
      @(posedge clk); #1;
      op = o; dst_loc = dl; src_loc = sl; dst_sz = ds; src_sz = ss;
      reg_in = rv; addr_in = a; start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
      while (n_done != n_pushed) @(posedge clk);
   endtask

   task automatic chk_mem(input logic [AW_T-1:0] a, input logic [7:0] e, input string tag);
      chk(mem[a] == e, tag, $sformatf("memory byte at %0h", a), 64'(mem[a]), 64'(e));
   endtask

   initial begin
      for (int i = 0; i < (1 << AW_T); i++) mem[i] = 8'h00;
      mem[10'h100] = 8'h00; mem[10'h101] = 8'hFF;
      mem[10'h180] = 8'h5A; mem[10'h181] = 8'hC3;
      for (int i = 0; i < 8; i++) mem[10'h200 + i] = 8'(8'h11 * (i + 1));

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !err && !mem_req, "R10", "idle outputs after reset",
          {60'd0, busy, done, err, mem_req}, 64'd0);

      // op: 0 move, 1 zext, 2 sext, 3 xchg, 4 lptr; loc: 0 reg, 1 mem, 2 imm
      run_op(3'd0, 2'd0, 2'd1, 2'd1, 2'd1, 32'h0, 10'h100, 0, 32'h0000FF00, 0, 0, 2, "R1");
      run_op(3'd2, 2'd0, 2'd0, 2'd2, 2'd1, 32'h8100, 10'h0, 0, 32'hFFFF8100, 0, 0, 0, "R3");
      run_op(3'd1, 2'd0, 2'd0, 2'd2, 2'd1, 32'h8100, 10'h0, 0, 32'h00008100, 0, 0, 0, "R2");
      run_op(3'd2, 2'd0, 2'd1, 2'd2, 2'd0, 32'h0, 10'h100, 0, 32'h00000000, 0, 0, 1, "R3");
      run_op(3'd2, 2'd0, 2'd1, 2'd2, 2'd1, 32'h0, 10'h100, 0, 32'hFFFFFF00, 0, 0, 2, "R3");
      run_op(3'd2, 2'd0, 2'd0, 2'd1, 2'd0, 32'h12345680, 10'h0, 0, 32'h0000FF80, 0, 0, 0, "R3");
      run_op(3'd1, 2'd0, 2'd1, 2'd1, 2'd0, 32'h0, 10'h101, 0, 32'h000000FF, 0, 0, 1, "R2");
      run_op(3'd0, 2'd0, 2'd2, 2'd0, 2'd0, 32'h123456AB, 10'h0, 0, 32'h000000AB, 0, 0, 0, "R4");
      run_op(3'd0, 2'd0, 2'd0, 2'd1, 2'd1, 32'hCAFE1234, 10'h0, 0, 32'h00001234, 0, 0, 0, "R4");
      run_op(3'd4, 2'd0, 2'd1, 2'd1, 2'd1, 32'h0, 10'h200, 0, 32'h00002211, 1, 16'h4433, 4, "R7");
      run_op(3'd4, 2'd0, 2'd1, 2'd2, 2'd2, 32'h0, 10'h200, 0, 32'h44332211, 1, 16'h6655, 6, "R7");

      run_op(3'd0, 2'd1, 2'd0, 2'd2, 2'd2, 32'hA1B2C3D4, 10'h300, 0, 32'hA1B2C3D4, 0, 0, 4, "R5");
      chk_mem(10'h300, 8'hD4, "R5"); chk_mem(10'h301, 8'hC3, "R5");
      chk_mem(10'h302, 8'hB2, "R5"); chk_mem(10'h303, 8'hA1, "R5");

      run_op(3'd3, 2'd1, 2'd0, 2'd2, 2'd2, 32'h01020304, 10'h300, 0, 32'hA1B2C3D4, 0, 0, 8, "R6");
      chk_mem(10'h300, 8'h04, "R6"); chk_mem(10'h303, 8'h01, "R6");

      stall_en = 1'b1;
      run_op(3'd3, 2'd1, 2'd0, 2'd1, 2'd1, 32'h0000BEEF, 10'h180, 0, 32'h0000C35A, 0, 0, 4, "R6 R9");
      chk_mem(10'h180, 8'hEF, "R6"); chk_mem(10'h181, 8'hBE, "R6");

      // R11: a second start during a stalled pointer load must be ignored
      fork
         run_op(3'd4, 2'd0, 2'd1, 2'd2, 2'd2, 32'h0, 10'h200, 0, 32'h44332211, 1, 16'h6655, 6, "R11");
         begin
            repeat (4) @(posedge clk);
            #2 start = 1'b1; dst_loc = 2'd2;
            @(posedge clk); #2 start = 1'b0;
         end
      join
      stall_en = 1'b0;

      // R8: illegal combinations
      run_op(3'd0, 2'd2, 2'd0, 2'd1, 2'd1, 32'h1, 10'h0, 1, 0, 0, 0, 0, "R8 imm dest");
      run_op(3'd1, 2'd0, 2'd2, 2'd2, 2'd0, 32'h1, 10'h0, 1, 0, 0, 0, 0, "R8 imm ext src");
      run_op(3'd1, 2'd0, 2'd1, 2'd1, 2'd1, 32'h1, 10'h100, 1, 0, 0, 0, 0, "R8 no widen");
      run_op(3'd2, 2'd1, 2'd0, 2'd2, 2'd0, 32'h1, 10'h100, 1, 0, 0, 0, 0, "R8 ext to mem");
      run_op(3'd3, 2'd0, 2'd1, 2'd1, 2'd1, 32'h1, 10'h100, 1, 0, 0, 0, 0, "R8 xchg mem src");
      run_op(3'd3, 2'd1, 2'd0, 2'd2, 2'd1, 32'h1, 10'h100, 1, 0, 0, 0, 0, "R8 xchg sizes");
      run_op(3'd4, 2'd0, 2'd1, 2'd0, 2'd0, 32'h1, 10'h200, 1, 0, 0, 0, 0, "R8 byte pointer");
      run_op(3'd0, 2'd1, 2'd1, 2'd1, 2'd1, 32'h1, 10'h100, 1, 0, 0, 0, 0, "R8 mem to mem");
      run_op(3'd5, 2'd0, 2'd0, 2'd1, 2'd1, 32'h1, 10'h0, 1, 0, 0, 0, 0, "R8 bad op");
      run_op(3'd0, 2'd0, 2'd0, 2'd3, 2'd3, 32'h1, 10'h0, 1, 0, 0, 0, 0, "R8 oversize");
      chk_mem(10'h100, 8'h00, "R8"); chk_mem(10'h101, 8'hFF, "R8");

      repeat (5) @(posedge clk);
      chk(sbq.size() == 0, "R11", "pending scoreboard entries", 64'(sbq.size()), 64'd0);
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule